// File: doc/BRIEF.md
# Generalized Mersenne Modular Reducer

This block takes a double-width product and returns its remainder modulo a prime-friendly modulus of the shape L = 2^k1 − 2^k2 − 1. Both exponents are picked per operation from small encoded fields, so one instance serves a whole family of moduli. It sits behind a residue-arithmetic multiplier that hands it products A < L^2, and it returns the fully reduced residue.

Reduction uses the identity 2^k1 ≡ 2^k2 + 1 (mod L). Each pipeline stage splits the running value at bit k1 and adds the high part back as a shift plus an add. Four such folds bring any legal input below 2^k1. One compare-and-subtract stage then finishes the job. The subtraction is always computed, and its borrow picks between the two candidates. Every operation therefore takes the same number of cycles whatever the operands, which keeps timing free of data dependence. A valid/ready pair at each side lets the consumer stall the pipeline.

Top module: `gm_reducer`

## Requirements
- R1: With k1 = 64 − in_k1_off (in_k1_off in 0..6) and k2 = in_k2 (legal when 1 ≤ k2 and 2·k2 ≤ k1), each accepted operand in_prod < L^2 yields out_res = in_prod mod L, where L = 2^k1 − 2^k2 − 1.
- R2: Every delivered out_res is strictly below the L of its own operation; after the last fold the running value is already below 2^k1.
- R3: While out_ready stays high, a result appears on out_valid/out_res after the fourth rising edge that follows the edge accepting its operand (five register stages), for every operand value and every (k1, k2).
- R4: Whenever out_ready is high, in_ready is high, so one operand per cycle is accepted back to back.
- R5: While out_valid is high and out_ready is low, out_valid stays high, out_res holds its value and in_ready is low.
- R6: Whenever out_valid is low, in_ready is high.
- R7: After synchronous reset (rst high), out_valid is low and in_ready is high.
- R8: Boundary operands reduce exactly: 0 gives 0, L−1 gives L−1, L gives 0, (L−1)^2 gives 1, and c·L + r gives r.
- R9: Results leave in the order their operands were accepted, with no result lost or duplicated under stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand accepted on this edge when in_valid is high |
| in_prod | input | 128 | Double-width operand, must be below L^2 |
| in_k1_off | input | 3 | Distance of k1 below 64 |
| in_k2 | input | 6 | Value of k2 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_res | output | 64 | Reduced residue, in [0, L) |

## Verification
The bench builds the block with its default of four folds and 64-bit residues. With these values every legal exponent pair, from k1 = 58 with k2 = 1 up to k1 = 64 with k2 = 32, can be swept exhaustively. That sweep reaches the widest first fold, where k2 = k1/2 lets the fold grow the most, and the tightest case for the final subtraction. A second phase randomises the consumer's ready. This exercises holding a result and stopping input acceptance in the middle of back-to-back traffic.

// File: rtl/gm_pkg.sv
package gm_pkg;

    // Widths of the reducer datapath
    localparam int K1_TOP = 64;                    // largest k1, also residue width
    localparam int OFF_W  = 3;                     // k1 offset field width
    localparam int K2_W   = 6;                     // k2 field width
    localparam int K1_W   = $clog2(K1_TOP + 1);    // holds k1 itself
    localparam int PROD_W = 2 * K1_TOP;            // operand width
    localparam int ACC_W  = PROD_W + 2;            // running value with fold headroom
    localparam int RES_W  = K1_TOP;                // result width

    typedef logic [ACC_W-1:0] acc_t;

    // One pipeline slot: valid flag, exponents and running value
    typedef struct packed {
        logic            vld;
        logic [K1_W-1:0] k1;
        logic [K2_W-1:0] k2;
        acc_t            val;
    } lane_t;

    function automatic logic [K1_W-1:0] k1_decode(input logic [OFF_W-1:0] off);
        return K1_W'(K1_TOP) - K1_W'(off);
    endfunction

    function automatic acc_t low_mask(input logic [K1_W-1:0] k1);
        return (acc_t'(1) << k1) - acc_t'(1);
    endfunction

    function automatic acc_t modulus(input logic [K1_W-1:0] k1, input logic [K2_W-1:0] k2);
        return (acc_t'(1) << k1) - (acc_t'(1) << k2) - acc_t'(1);
    endfunction

endpackage

// File: rtl/gm_fold_stage.sv
module gm_fold_stage
    import gm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  lane_t d,
    output lane_t q
);

    acc_t hi;
    acc_t lo;
    acc_t folded;

    // value = hi*2^k1 + lo  ==  hi*(2^k2 + 1) + lo  (mod L)
    always_comb begin
        hi     = d.val >> d.k1;
        lo     = d.val & low_mask(d.k1);
        folded = lo + (hi << d.k2) + hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q     <= d;
            q.val <= folded;
        end
    end

endmodule

// File: rtl/gm_final_sub.sv
module gm_final_sub
    import gm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  lane_t d,
    output lane_t q
);

    logic [ACC_W:0] diff;
    acc_t           pick;

    // Subtraction always evaluated; borrow keeps the unsubtracted value
    always_comb begin
        diff = {1'b0, d.val} - {1'b0, modulus(d.k1, d.k2)};
        pick = diff[ACC_W] ? d.val : diff[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q     <= d;
            q.val <= pick;
        end
    end

endmodule

// File: rtl/gm_reducer.sv
module gm_reducer
    import gm_pkg::*;
#(
    parameter int NUM_FOLDS = 4     // four folds bound any legal operand below 2^k1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PROD_W-1:0] in_prod,
    input  logic [OFF_W-1:0]  in_k1_off,
    input  logic [K2_W-1:0]   in_k2,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [RES_W-1:0]  out_res
);

    lane_t stg [NUM_FOLDS+1];
    lane_t pre_sub;
    lane_t fin_q;
    logic  adv;

    // Whole pipeline moves together unless the result slot is blocked
    assign adv      = !fin_q.vld || out_ready;
    assign in_ready = adv;

    assign stg[0] = '{vld: in_valid,
                      k1:  k1_decode(in_k1_off),
                      k2:  in_k2,
                      val: acc_t'(in_prod)};

    for (genvar g = 0; g < NUM_FOLDS; g++) begin : g_fold
        gm_fold_stage u_fold (
            .clk (clk),
            .rst (rst),
            .en  (adv),
            .d   (stg[g]),
            .q   (stg[g+1])
        );
    end

    assign pre_sub = stg[NUM_FOLDS];

    gm_final_sub u_final (
        .clk (clk),
        .rst (rst),
        .en  (adv),
        .d   (pre_sub),
        .q   (fin_q)
    );

    assign out_valid = fin_q.vld;
    assign out_res   = fin_q.val[RES_W-1:0];

endmodule

// File: rtl/gm_reducer_chk.sv
module gm_reducer_chk
    import gm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             out_valid,
    input logic             out_ready,
    input logic [RES_W-1:0] out_res,
    input lane_t            pre,
    input lane_t            fin
);

    AST_RES_BELOW_MOD: assert property (@(posedge clk) disable iff (rst)
        fin.vld |-> (fin.val < modulus(fin.k1, fin.k2)));                    // R2

    AST_FOLD_BOUND: assert property (@(posedge clk) disable iff (rst)
        pre.vld |-> ((pre.val >> pre.k1) == '0));                            // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));      // R5

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);                                          // R7

    AST_OUT_FROM_PIPE: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(pre.vld));                                // R3

endmodule

bind gm_reducer gm_reducer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_res   (out_res),
    .pre       (pre_sub),
    .fin       (fin_q)
);

// File: tb/tb_gm_reducer.sv
module tb_gm_reducer;
    import gm_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [PROD_W-1:0] in_prod = '0;
    logic [OFF_W-1:0]  in_k1_off = '0;
    logic [K2_W-1:0]   in_k2 = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [RES_W-1:0]  out_res;

    always #5 clk = ~clk;   // 100 MHz

    gm_reducer dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_prod   (in_prod),
        .in_k1_off (in_k1_off),
        .in_k2     (in_k2),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_res   (out_res)
    );

    typedef struct {
        logic [PROD_W-1:0] expv;
        logic [PROD_W-1:0] modv;
        int                edge_no;
        string             tag;
    } exp_t;

    exp_t  pend[$];
    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    lat_mode = 1'b1;
    bit    head_seen = 1'b0;
    bit    done = 1'b0;
    bit    stall_run = 1'b0;
    string cur_tag = "R1";

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [PROD_W-1:0] mod_of(input int k1, input int k2);
        return (PROD_W'(1) << k1) - (PROD_W'(1) << k2) - PROD_W'(1);
    endfunction

    function automatic logic [PROD_W-1:0] rand_wide();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [PROD_W-1:0] act, input logic [PROD_W-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Behavioural reference: queue of expected results, compared every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (in_valid && in_ready) begin
                exp_t e;
                int   k1;
                k1 = K1_TOP - int'(in_k1_off);
                e.modv    = mod_of(k1, int'(in_k2));
                e.expv    = in_prod % e.modv;
                e.edge_no = cyc + 1;
                e.tag     = cur_tag;
                pend.push_back(e);
            end
            if (out_ready)
                check(in_ready == 1'b1, "R4", PROD_W'(in_ready), 1);
            if (out_valid) begin
                if (pend.size() == 0) begin
                    check(1'b0, "R9", PROD_W'(out_res), 0);
                end else begin
                    check(PROD_W'(out_res) == pend[0].expv, pend[0].tag, PROD_W'(out_res), pend[0].expv);
                    check(PROD_W'(out_res) < pend[0].modv, "R2", PROD_W'(out_res), pend[0].modv);
                    if (!head_seen && lat_mode)
                        check(cyc == pend[0].edge_no + 4, "R3", PROD_W'(cyc), PROD_W'(pend[0].edge_no + 4));
                    head_seen = 1'b1;
                    if (out_ready) begin
                        void'(pend.pop_front());
                        head_seen = 1'b0;
                    end else begin
                        check(in_ready == 1'b0, "R5", PROD_W'(in_ready), 0);
                    end
                end
            end else begin
                check(in_ready == 1'b1, "R6", PROD_W'(in_ready), 1);
            end
        end
    end

    task automatic send(input logic [PROD_W-1:0] a, input int off, input int k2, input string tag);
        in_valid  = 1'b1;
        in_prod   = a;
        in_k1_off = OFF_W'(off);
        in_k2     = K2_W'(k2);
        cur_tag   = tag;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #2;
        in_valid = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Consumer ready randomiser for the stall phase
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (stall_run) out_ready = ($urandom % 3) != 0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R7", PROD_W'(out_valid), 0);
        check(in_ready == 1'b1, "R7", PROD_W'(in_ready), 1);
        @(posedge clk);
        #2;

        // Phase 1: every legal exponent pair, consumer always ready
        lat_mode = 1'b1;
        for (int off = 0; off <= 6; off++) begin
            for (int k2 = 1; 2 * k2 <= K1_TOP - off; k2++) begin
                logic [PROD_W-1:0] m;
                m = mod_of(K1_TOP - off, k2);
                send('0, off, k2, "R8");
                send(m - 1, off, k2, "R8");
                send(m, off, k2, "R8");
                send((m - 1) * (m - 1), off, k2, "R8");
                send(m * PROD_W'(5 + k2) + PROD_W'(off + 3), off, k2, "R8");
                send(rand_wide() % (m * m), off, k2, "R1");
                send(rand_wide() % (m * m), off, k2, "R1");
            end
        end
        repeat (10) @(posedge clk);
        #2;

        // Phase 2: random pairs under a stalling consumer
        lat_mode  = 1'b0;
        stall_run = 1'b1;
        for (int n = 0; n < 400; n++) begin
            int off;
            int k2;
            logic [PROD_W-1:0] m;
            off = int'($urandom % 7);
            k2  = 1 + int'($urandom % ((K1_TOP - off) / 2));
            m   = mod_of(K1_TOP - off, k2);
            send(rand_wide() % (m * m), off, k2, "R9");
        end
        stall_run = 1'b0;
        @(posedge clk);
        #2;
        out_ready = 1'b1;
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(pend.size() == 0, "R9", PROD_W'(pend.size()), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule